// File: doc/BRIEF.md
# Guarded Byte-Store Write Controller

This block fronts a small byte-wide store that stands in for on-chip nonvolatile data memory. A CPU reaches it through a four-register bus window: an address pointer, a data holding register, a control/status register, and a key register that is only ever written. A read is a single-cycle operation. The CPU loads the pointer, sets the read bit, and finds the addressed byte in the data register on the following cycle.

Writes are guarded against runaway code. The CPU loads the pointer and the data register and sets the write-enable bit. It then writes the two key bytes into the key register on back-to-back clock cycles, and on the very next cycle sets the write bit. A timed busy phase then models the programming time. During this phase the pointer, the data register and new reads are frozen. At the end, the byte is committed and a sticky completion flag rises. The completion flag can drive an interrupt line through a mask bit.

Top module: `nvbyte_guard`

## Requirements
- R1: Writing the control register (offset 2) with bit 0 set while no write is busy loads the byte at the pointer (offset 0) into the data register (offset 1). The new value is readable on the next cycle. Bit 0 always reads back as 0.
- R2: The data register changes only on a read request or a direct CPU write to offset 1. Changing the pointer does not change it, and neither does a rejected write.
- R3: A write starts only under three conditions. 8'h55 is written to the key register (offset 3). 8'hAA is written to offset 3 on the next cycle. A control write with bit 1 set follows on the cycle after that, with the write-enable bit (control bit 2) already set.
- R4: A control write with bit 1 set is rejected in several cases: the key bytes were wrong or out of order, any idle cycle or other bus access broke the sequence, or no sequence was given at all. A rejected write starts nothing and sets the sticky error flag (control bit 5).
- R5: A correct key sequence does not start a write if the write-enable bit was clear before the write-bit access. The error flag is set instead.
- R6: Once started, bit 1 reads 1 for exactly WR_CYCLES cycles. Hardware then clears it, stores the data byte at the pointer, and sets the completion flag (control bit 3).
- R7: Clearing write-enable during a busy write does not stop that write. Hardware never clears write-enable.
- R8: The completion and error flags stay set until software writes 0 to their bit position. Writing 1 to either flag never sets it.
- R9: While a write is busy, read requests and writes to the pointer or the data register are ignored.
- R10: After reset, the pointer, the data register and the control register read 0, and the key state is idle. The key register always reads 0.
- R11: irqOut equals the completion flag ANDed with the interrupt-enable bit (control bit 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWe | input | 1 | 1 = write access, 0 = read access |
| busAddr | input | 2 | Register offset (0 pointer, 1 data, 2 control, 3 key) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| irqOut | output | 1 | Completion interrupt request |

## Verification
Every register write takes effect at the clock edge that samples it. The bench drives on falling edges and peeks the combinational read port half a cycle after that edge, so a read result, a rejection or the start of a write is checked in the cycle right after the access. The write busy bit is checked twice: once WR_CYCLES-1 cycles after the starting edge, where it must still be high, and one cycle later, where it must have dropped with the completion flag set. Peeks do not assert busSel, so observing the block never breaks a key sequence.

// File: rtl/nvbyte_pkg.sv
package nvbyte_pkg;
  localparam int BYTE_W = 8;

  localparam logic [1:0] OFS_PTR  = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;
  localparam logic [1:0] OFS_KEY  = 2'd3;

  localparam int BIT_RD    = 0;
  localparam int BIT_WR    = 1;
  localparam int BIT_WREN  = 2;
  localparam int BIT_DONE  = 3;
  localparam int BIT_IRQEN = 4;
  localparam int BIT_ERR   = 5;

  localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;

  typedef struct packed {
    logic rdFire;
    logic wrFinish;
    logic ptrWe;
    logic dataWe;
    logic busy;
  } strobe_t;

  typedef enum logic [1:0] {KEY_IDLE, KEY_HALF, KEY_ARMED} keyState_t;
endpackage

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl
  import nvbyte_pkg::*;
#(
  parameter int WR_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [1:0]        busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output strobe_t           stb,
  output logic [BYTE_W-1:0] ctrlByte,
  output logic              irq
);
  localparam int CNT_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;

  logic             busyQ, wrEnQ, irqEnQ, doneQ, errQ;
  logic [CNT_W-1:0] cntQ;
  keyState_t        keyQ, keyNext;

  logic ctrlWr, keyWr, wrReq, wrStart, wrReject, wrFinish;

  assign ctrlWr   = busSel && busWe && (busAddr == OFS_CTRL);
  assign keyWr    = busSel && busWe && (busAddr == OFS_KEY);
  assign wrReq    = ctrlWr && busWdata[BIT_WR] && !busyQ;
  assign wrStart  = wrReq && (keyQ == KEY_ARMED) && wrEnQ;
  assign wrReject = wrReq && !wrStart;
  assign wrFinish = busyQ && (cntQ == '0);

  always_comb begin
    if (keyWr && busWdata == KEY_FIRST)
      keyNext = KEY_HALF;
    else if (keyQ == KEY_HALF && keyWr && busWdata == KEY_SECOND)
      keyNext = KEY_ARMED;
    else
      keyNext = KEY_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      cntQ   <= '0;
      wrEnQ  <= 1'b0;
      irqEnQ <= 1'b0;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
      keyQ   <= KEY_IDLE;
    end else begin
      if (wrStart) begin
        busyQ <= 1'b1;
        cntQ  <= CNT_W'(WR_CYCLES - 1);
      end else if (wrFinish) begin
        busyQ <= 1'b0;
      end else if (busyQ) begin
        cntQ <= cntQ - 1'b1;
      end
      if (ctrlWr) begin
        wrEnQ  <= busWdata[BIT_WREN];
        irqEnQ <= busWdata[BIT_IRQEN];
      end
      doneQ <= (doneQ && !(ctrlWr && !busWdata[BIT_DONE])) || wrFinish;
      errQ  <= (errQ && !(ctrlWr && !busWdata[BIT_ERR])) || wrReject;
      keyQ  <= keyNext;
    end
  end

  assign stb.rdFire   = ctrlWr && busWdata[BIT_RD] && !busyQ;
  assign stb.wrFinish = wrFinish;
  assign stb.ptrWe    = busSel && busWe && (busAddr == OFS_PTR) && !busyQ;
  assign stb.dataWe   = busSel && busWe && (busAddr == OFS_DATA) && !busyQ;
  assign stb.busy     = busyQ;

  assign ctrlByte = {2'b00, errQ, irqEnQ, doneQ, wrEnQ, busyQ, 1'b0};
  assign irq      = doneQ && irqEnQ;

  // R3 R5
  start_needs_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> ($past(wrEnQ) && $past(keyQ == KEY_ARMED)));

  // R6
  finish_sets_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> doneQ);

  // R7
  wren_sw_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrEnQ) |-> $past(ctrlWr));
endmodule

// File: rtl/nvbyte_datapath.sv
module nvbyte_datapath
  import nvbyte_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [1:0]        busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  input  logic [BYTE_W-1:0] ctrlByte,
  output logic [BYTE_W-1:0] busRdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] ptrQ;
  logic [BYTE_W-1:0] dataQ;
  logic [BYTE_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ  <= '0;
      dataQ <= '0;
    end else begin
      if (stb.ptrWe) ptrQ <= busWdata[ADDR_W-1:0];
      if (stb.rdFire)      dataQ <= store[ptrQ];
      else if (stb.dataWe) dataQ <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrFinish) store[ptrQ] <= dataQ;
  end

  always_comb begin
    case (busAddr)
      OFS_PTR:  busRdata = BYTE_W'(ptrQ);
      OFS_DATA: busRdata = dataQ;
      OFS_CTRL: busRdata = ctrlByte;
      default:  busRdata = '0;
    endcase
  end

  // R9
  frozen_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.busy) |-> ($stable(ptrQ) && $stable(dataQ)));

  // R10
  key_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFS_KEY) |-> (busRdata == '0));
endmodule

// File: rtl/nvbyte_guard.sv
module nvbyte_guard
  import nvbyte_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WR_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWe,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       irqOut
);
  strobe_t           stb;
  logic [BYTE_W-1:0] ctrlByte;

  nvbyte_ctrl #(.WR_CYCLES(WR_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata),
    .stb(stb), .ctrlByte(ctrlByte), .irq(irqOut)
  );

  nvbyte_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr),
    .busWdata(busWdata), .ctrlByte(ctrlByte), .busRdata(busRdata)
  );
endmodule

// File: tb/nvbyte_guard_tb.sv
module nvbyte_guard_tb_top;
  localparam int W = 8;
  localparam int NVEC = 5;
  // each entry: {address, data}
  localparam logic [15:0] VEC [NVEC] = '{16'h00_3C, 16'hFF_A5, 16'h5A_01, 16'h13_C3, 16'h80_FF};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWe = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic irqOut;
  int nRun = 0, nFail = 0;

  always #4 clk = ~clk;

  nvbyte_guard #(.ADDR_W(8), .WR_CYCLES(W)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic rdAccess(input logic [1:0] a);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    busSel = 1'b0; busWe = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    busSel = 1'b0; busWe = 1'b0; busAddr = a;
    #1 v = busRdata;
  endtask

  task automatic startWrite(input logic [7:0] a, input logic [7:0] d, input logic [7:0] extra);
    wr(2'd0, a); wr(2'd1, d); wr(2'd2, 8'h04 | extra);
    wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h06 | extra);
  endtask

  task automatic readBack(input logic [7:0] a, output logic [7:0] v);
    wr(2'd0, a); wr(2'd2, 8'h01);
    peek(2'd1, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] old13;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    peek(2'd0, v); chk("R10 ptr", v, 8'h00);
    peek(2'd1, v); chk("R10 data", v, 8'h00);
    peek(2'd2, v); chk("R10 ctrl", v, 8'h00);
    peek(2'd3, v); chk("R10 key", v, 8'h00);
    chk("R11 irq reset", {7'd0, irqOut}, 8'h00);

    // R3 R6: vector table, full guarded write per entry
    for (int i = 0; i < NVEC; i++) begin
      startWrite(VEC[i][15:8], VEC[i][7:0], 8'h00);
      peek(2'd2, v); chk("R3 busy after start", v, 8'h06);
      idle(W - 1);
      peek(2'd2, v); chk("R6 still busy", v, 8'h06);
      idle(1);
      peek(2'd2, v); chk("R6 done and R7 wren kept", v, 8'h0C);
    end
    // R1 readback of the table
    for (int i = 0; i < NVEC; i++) begin
      readBack(VEC[i][15:8], v);
      chk("R1 readback", v, VEC[i][7:0]);
      peek(2'd2, v); chk("R1 rd bit reads 0", v, 8'h00);
    end

    // R2 data holds
    readBack(8'h13, old13);
    wr(2'd0, 8'hFF); idle(5);
    peek(2'd1, v); chk("R2 hold after ptr change", v, 8'hC3);
    wr(2'd1, 8'h3C);
    peek(2'd1, v); chk("R2 direct write", v, 8'h3C);

    // R4 wrong key bytes
    wr(2'd0, 8'h13); wr(2'd1, 8'h99); wr(2'd2, 8'h04);
    wr(2'd3, 8'h55); wr(2'd3, 8'hAB); wr(2'd2, 8'h06);
    peek(2'd2, v); chk("R4 wrong key", v, 8'h24);
    wr(2'd2, 8'h04);
    peek(2'd2, v); chk("R8 err cleared by 0", v, 8'h04);
    wr(2'd2, 8'h24);
    peek(2'd2, v); chk("R8 err not set by 1", v, 8'h04);
    // R4 reversed order
    wr(2'd3, 8'hAA); wr(2'd3, 8'h55); wr(2'd2, 8'h06);
    peek(2'd2, v); chk("R4 reversed", v, 8'h24);
    // R4 gap between key bytes
    wr(2'd2, 8'h04); wr(2'd3, 8'h55); idle(1); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
    peek(2'd2, v); chk("R4 gap", v, 8'h24);
    // R4 gap before write bit
    wr(2'd2, 8'h04); wr(2'd3, 8'h55); wr(2'd3, 8'hAA); idle(1); wr(2'd2, 8'h06);
    peek(2'd2, v); chk("R4 late wr bit", v, 8'h24);
    // R4 intervening read access
    wr(2'd2, 8'h04); wr(2'd3, 8'h55); rdAccess(2'd1); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
    peek(2'd2, v); chk("R4 intervening access", v, 8'h24);
    // R4 no sequence at all
    wr(2'd2, 8'h04); wr(2'd2, 8'h06);
    peek(2'd2, v); chk("R4 no key", v, 8'h24);
    // R5 key fine but wren clear
    wr(2'd2, 8'h00); wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, 8'h06);
    peek(2'd2, v); chk("R5 wren clear", v, 8'h24);
    idle(W + 2);
    peek(2'd1, v); chk("R2 hold after rejected write", v, 8'h99);
    readBack(8'h13, v); chk("R4 R5 store unchanged", v, old13);

    // R7 clearing wren during busy
    startWrite(8'h21, 8'h5E, 8'h00);
    wr(2'd2, 8'h00);
    peek(2'd2, v); chk("R7 busy despite wren clear", v, 8'h02);
    idle(W - 2);
    peek(2'd2, v); chk("R7 still busy", v, 8'h02);
    idle(1);
    peek(2'd2, v); chk("R7 completes", v, 8'h08);
    // R8 done sticky
    idle(20);
    peek(2'd2, v); chk("R8 done sticky", v, 8'h08);
    wr(2'd2, 8'h00);
    peek(2'd2, v); chk("R8 done cleared", v, 8'h00);
    wr(2'd2, 8'h08);
    peek(2'd2, v); chk("R8 done not set by 1", v, 8'h00);
    readBack(8'h21, v); chk("R7 stored", v, 8'h5E);

    // R9 ignored accesses during busy
    startWrite(8'h40, 8'h77, 8'h00);
    wr(2'd0, 8'h41); wr(2'd1, 8'h99); wr(2'd2, 8'h07);
    peek(2'd0, v); chk("R9 ptr frozen", v, 8'h40);
    peek(2'd1, v); chk("R9 data frozen", v, 8'h77);
    peek(2'd2, v); chk("R9 busy kept", v, 8'h06);
    idle(W);
    readBack(8'h40, v); chk("R9 stored at original ptr", v, 8'h77);

    // R11 interrupt masking
    startWrite(8'h55, 8'h12, 8'h10);
    idle(W);
    chk("R11 irq on", {7'd0, irqOut}, 8'h01);
    wr(2'd2, 8'h0C);
    chk("R11 irq masked", {7'd0, irqOut}, 8'h00);
    wr(2'd2, 8'h1C);
    chk("R11 irq unmasked", {7'd0, irqOut}, 8'h01);
    wr(2'd2, 8'h14);
    chk("R11 irq cleared", {7'd0, irqOut}, 8'h00);
    peek(2'd3, v); chk("R10 key still zero", v, 8'h00);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule